// File: doc/BRIEF.md
# DMA Channel Condition and Status Register

This block is the per-channel condition and status register of a DMA controller. The channel engine reports six kinds of transfer event as one-cycle pulses: split transfer, frame done, last frame, block done, read drop and write drop. Each pulse sets a sticky flag. Each flag has its own interrupt enable. The channel interrupt is raised whenever an enabled flag is set. Software clears a flag by writing a zero to it.

Two further sticky bits record that a read or a write synchronization event has arrived. Each of these has a companion write-one-to-clear bit that always reads as zero. A three-bit selector decides what drives a dedicated output pin: a constant level, one of the two sync status bits, or the frame or block flag.

Access is through a flat 32-bit port. A write strobe loads the whole word in one cycle, and the read data always shows the current contents. Address decoding is done outside the block.

Top module: `chan_cond_reg`

## Requirements
- R1: After reset the read word is 0x0000_0080 (only the block-done enable, bit 7, is one), `irq` is 0 and `pin_out` is 0.
- R2: A pulse on `cond_evt[k]` sets flag k, which reads at bit 2k one cycle later and stays set. Index order k=0..5 is split, frame, last, block, read drop, write drop.
- R3: A write with bit 2k at 0 clears flag k. A write with bit 2k at 1 leaves flag k unchanged, so a clear flag stays clear.
- R4: When a pulse on `cond_evt[k]` and a clearing write arrive in the same cycle, flag k ends up set.
- R5: The interrupt enable of flag k is bit 2k+1. It is loaded by every write and reads back as written.
- R6: `rsync_evt` sets the read-sync status at bit 12, and `wsync_evt` sets the write-sync status at bit 14. A write to bit 12 or bit 14 does not change either status.
- R7: A write with bit 13 (read) or bit 15 (write) at 1 clears the matching sync status, and a 0 in that bit has no effect. A sync event in the same cycle as the clear wins. Bits 13 and 15 always read 0.
- R8: The selector is bits 18:16 and reads back as written. It drives `pin_out` as follows: 000 low, 001 high, 010 read-sync status, 011 write-sync status, 100 frame flag, 101 block flag.
- R9: Selector codes 110 and 111 drive `pin_out` low.
- R10: Bits 31:19 read 0 whatever was written to them.
- R11: `irq` is registered. After each clock edge it equals the OR, over all k, of (flag k AND enable k) as those bits stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| cond_evt | input | 6 | One-cycle condition pulses from the channel engine |
| rsync_evt | input | 1 | Read synchronization event pulse |
| wsync_evt | input | 1 | Write synchronization event pulse |
| irq | output | 1 | Channel interrupt, registered |
| pin_out | output | 1 | Selectable external status pin |

## Verification
The assertions assume that every input is a clean level sampled at the rising edge, and that `rst_n` is held low for at least one edge before use. The assertions make no assumption about how often events arrive or about their overlap with writes. The stimulus changes every input only on falling edges. It mixes random writes with sparse random event pulses, so set/clear collisions and write-one-to-clear collisions occur on their own. Directed sequences force the exact collisions and every selector code.

// File: rtl/chan_cond_pkg.sv
package chan_cond_pkg;
  localparam int CSR_W     = 32;
  localparam int N_COND    = 6;
  localparam int N_SYNC    = 2;
  localparam int SEL_W     = 3;
  localparam int SYNC_BASE = 2 * N_COND;            // 12
  localparam int SEL_LSB   = SYNC_BASE + 2 * N_SYNC; // 16
  localparam int RSVD_LSB  = SEL_LSB + SEL_W;        // 19

  localparam int C_SPLIT = 0;
  localparam int C_FRAME = 1;
  localparam int C_LAST  = 2;
  localparam int C_BLOCK = 3;
  localparam int C_RDROP = 4;
  localparam int C_WDROP = 5;

  localparam logic [N_COND-1:0] IEN_RST = N_COND'(1) << C_BLOCK;

  typedef enum logic [SEL_W-1:0] {
    PIN_LOW   = 3'd0,
    PIN_HIGH  = 3'd1,
    PIN_RSYNC = 3'd2,
    PIN_WSYNC = 3'd3,
    PIN_FRAME = 3'd4,
    PIN_BLOCK = 3'd5
  } pin_sel_e;

  function automatic logic pin_pick(logic [SEL_W-1:0] sel, logic rs, logic ws,
                                    logic fr, logic bl);
    logic v;
    case (sel)
      PIN_LOW:   v = 1'b0;
      PIN_HIGH:  v = 1'b1;
      PIN_RSYNC: v = rs;
      PIN_WSYNC: v = ws;
      PIN_FRAME: v = fr;
      PIN_BLOCK: v = bl;
      default:   v = 1'b0;
    endcase
    return v;
  endfunction

  function automatic logic irq_hit(logic [N_COND-1:0] f, logic [N_COND-1:0] e);
    return |(f & e);
  endfunction

  function automatic logic [CSR_W-1:0] pack_csr(logic [N_COND-1:0] f,
                                                logic [N_COND-1:0] e,
                                                logic [N_SYNC-1:0] st,
                                                logic [SEL_W-1:0] sel);
    logic [CSR_W-1:0] w;
    w = '0;
    for (int i = 0; i < N_COND; i++) begin
      w[2*i]   = f[i];
      w[2*i+1] = e[i];
    end
    for (int j = 0; j < N_SYNC; j++) begin
      w[SYNC_BASE+2*j] = st[j];
    end
    w[SEL_LSB +: SEL_W] = sel;
    return w;
  endfunction
endpackage

// File: rtl/chan_cond_flags.sv
module chan_cond_flags
  import chan_cond_pkg::*;
#(
  parameter int N = N_COND,
  parameter logic [N-1:0] EN_RST = IEN_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] wr_cond,
  input  logic [N-1:0] wr_ien,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] ien_q
);
  // software clear request per flag: a written zero
  logic [N-1:0] sw_clr;

  for (genvar k = 0; k < N; k++) begin : g_bit
    assign sw_clr[k] = wr_en & ~wr_cond[k];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[k] <= 1'b0;
        ien_q[k]  <= EN_RST[k];
      end else begin
        if (set_evt[k])     flag_q[k] <= 1'b1;
        else if (sw_clr[k]) flag_q[k] <= 1'b0;
        if (wr_en)          ien_q[k]  <= wr_ien[k];
      end
    end

    // R2 / R4: a pulse always leaves the flag set, even against a clear
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[k] |=> flag_q[k]);
    // R3: no flag rises without an event, whatever software writes
    p_noset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_evt[k] && !flag_q[k]) |=> !flag_q[k]);
    // R3: a written zero clears when no event competes
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr[k] && !set_evt[k]) |=> !flag_q[k]);
  end
endmodule

// File: rtl/chan_sync_bit.sv
module chan_sync_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr_wr,
  output logic status_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      status_q <= 1'b0;
    else if (evt)    status_q <= 1'b1;
    else if (clr_wr) status_q <= 1'b0;
  end

  // R6: without event or clear the status holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !clr_wr) |=> status_q == $past(status_q));
  // R7: write-one clear takes effect
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !evt) |=> !status_q);
  // R7: event beats a simultaneous clear
  p_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> status_q);
endmodule

// File: rtl/chan_pin_mux.sv
module chan_pin_mux
  import chan_cond_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             rsync_st,
  input  logic             wsync_st,
  input  logic             frame_f,
  input  logic             block_f,
  output logic             pin
);
  assign pin = pin_pick(sel, rsync_st, wsync_st, frame_f, block_f);

  // R9: unassigned codes hold the pin low
  p_rsvd_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2] && sel[1]) |-> !pin);
  // R8: code 001 drives high
  p_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == PIN_HIGH) |-> pin);
endmodule

// File: rtl/chan_cond_reg.sv
module chan_cond_reg
  import chan_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSR_W-1:0]  wr_data,
  output logic [CSR_W-1:0]  rd_data,
  input  logic [N_COND-1:0] cond_evt,
  input  logic              rsync_evt,
  input  logic              wsync_evt,
  output logic              irq,
  output logic              pin_out
);
  logic [N_COND-1:0] wr_cond, wr_ien, flag_q, ien_q;
  logic [N_SYNC-1:0] sync_evt, sync_clr, sync_st;
  logic [SEL_W-1:0]  sel_q;
  logic              irq_q;
  logic              unused_wr;

  for (genvar k = 0; k < N_COND; k++) begin : g_split
    assign wr_cond[k] = wr_data[2*k];
    assign wr_ien[k]  = wr_data[2*k+1];
  end

  assign sync_evt = {wsync_evt, rsync_evt};

  chan_cond_flags #(.N(N_COND), .EN_RST(IEN_RST)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .set_evt(cond_evt),
    .wr_cond(wr_cond), .wr_ien(wr_ien), .flag_q(flag_q), .ien_q(ien_q)
  );

  for (genvar j = 0; j < N_SYNC; j++) begin : g_sync
    assign sync_clr[j] = wr_en & wr_data[SYNC_BASE+2*j+1];
    chan_sync_bit u_sync (
      .clk(clk), .rst_n(rst_n), .evt(sync_evt[j]),
      .clr_wr(sync_clr[j]), .status_q(sync_st[j])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= PIN_LOW;
      irq_q <= 1'b0;
    end else begin
      if (wr_en) sel_q <= wr_data[SEL_LSB +: SEL_W];
      irq_q <= irq_hit(flag_q, ien_q);
    end
  end

  chan_pin_mux u_pin (
    .clk(clk), .rst_n(rst_n), .sel(sel_q),
    .rsync_st(sync_st[0]), .wsync_st(sync_st[1]),
    .frame_f(flag_q[C_FRAME]), .block_f(flag_q[C_BLOCK]), .pin(pin_out)
  );

  assign rd_data   = pack_csr(flag_q, ien_q, sync_st, sel_q);
  assign irq       = irq_q;
  assign unused_wr = ^{wr_data[CSR_W-1:RSVD_LSB], wr_data[SYNC_BASE+2],
                       wr_data[SYNC_BASE]};

  // R11: no enabled flag means the interrupt is low next cycle
  p_irq_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ien_q) == '0) |=> !irq);
  // R11: an enabled flag raises the interrupt next cycle
  p_irq_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ien_q) != '0) |=> irq);
endmodule

// File: tb/chan_cond_reg_tb_top.sv
`timescale 1ns/1ps
module chan_cond_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [5:0]  cond_evt;
  logic        rsync_evt, wsync_evt;
  logic        irq, pin_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [5:0] m_cond, m_en;
  logic       m_rs, m_ws, m_irq;
  logic [2:0] m_sel;

  always #2.5 clk = ~clk;

  chan_cond_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cond_evt(cond_evt), .rsync_evt(rsync_evt),
    .wsync_evt(wsync_evt), .irq(irq), .pin_out(pin_out)
  );

  function automatic logic [5:0] even_bits(logic [31:0] w);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = w[2*i];
    return r;
  endfunction

  function automatic logic [5:0] odd_bits(logic [31:0] w);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = w[2*i+1];
    return r;
  endfunction

  function automatic logic exp_pin(logic [2:0] s, logic rs, logic ws,
                                   logic [5:0] c);
    if (s == 3'd1) return 1'b1;
    if (s == 3'd2) return rs;
    if (s == 3'd3) return ws;
    if (s == 3'd4) return c[1];
    if (s == 3'd5) return c[3];
    return 1'b0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic we, logic [31:0] d, logic [5:0] ce,
                      logic rse, logic wse);
    wr_en = we; wr_data = d; cond_evt = ce; rsync_evt = rse; wsync_evt = wse;
    @(posedge clk);
    m_irq = |(m_cond & m_en);
    for (int i = 0; i < 6; i++) begin
      if (ce[i])            m_cond[i] = 1'b1;
      else if (we && !d[2*i]) m_cond[i] = 1'b0;
      if (we) m_en[i] = d[2*i+1];
    end
    if (rse) m_rs = 1'b1; else if (we && d[13]) m_rs = 1'b0;
    if (wse) m_ws = 1'b1; else if (we && d[15]) m_ws = 1'b0;
    if (we) m_sel = d[18:16];
    @(negedge clk);
    wr_en = 0; wr_data = '0; cond_evt = '0; rsync_evt = 0; wsync_evt = 0;
    chk("R2 flags", 32'(even_bits(rd_data)), 32'(m_cond));
    chk("R5 enables", 32'(odd_bits(rd_data)), 32'(m_en));
    chk("R6 sync status", {30'd0, rd_data[14], rd_data[12]}, {30'd0, m_ws, m_rs});
    chk("R7 clear bits read zero", {30'd0, rd_data[15], rd_data[13]}, 32'd0);
    chk("R8 selector", 32'(rd_data[18:16]), 32'(m_sel));
    chk("R10 reserved", 32'(rd_data[31:19]), 32'd0);
    chk("R8 pin", 32'(pin_out), 32'(exp_pin(m_sel, m_rs, m_ws, m_cond)));
    chk("R11 irq", 32'(irq), 32'(m_irq));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; wr_en = 0; wr_data = '0; cond_evt = '0;
    rsync_evt = 0; wsync_evt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_cond = '0; m_en = 6'b001000; m_rs = 0; m_ws = 0; m_sel = 3'd0; m_irq = 0;
    chk("R1 reset word", rd_data, 32'h0000_0080);
    chk("R1 reset irq", 32'(irq), 32'd0);
    chk("R1 reset pin", 32'(pin_out), 32'd0);

    // R11: interrupt lags the flag by one cycle
    step(1, 32'h0000_0008, 6'd0, 0, 0);
    step(0, 32'h0, 6'b000010, 0, 0);
    chk("R2 frame set", 32'(rd_data[2]), 32'd1);
    chk("R11 irq lag", 32'(irq), 32'd0);
    step(0, 32'h0, 6'd0, 0, 0);
    chk("R11 irq up", 32'(irq), 32'd1);
    chk("R2 frame sticky", 32'(rd_data[2]), 32'd1);

    // R3: written one ignored, written zero clears
    step(1, 32'h0000_0009, 6'd0, 0, 0);
    chk("R3 write one no set", 32'(rd_data[0]), 32'd0);
    chk("R3 write zero clears", 32'(rd_data[2]), 32'd0);

    // R4: collision of pulse and clear
    step(0, 32'h0, 6'b001000, 0, 0);
    step(1, 32'h0000_0008, 6'b001000, 0, 0);
    chk("R4 set wins", 32'(rd_data[6]), 32'd1);

    // R5: enable pattern
    step(1, 32'h0000_0AAA, 6'd0, 0, 0);
    chk("R5 all enables", 32'(odd_bits(rd_data)), 32'h3F);

    // R6: event sets, software cannot set
    step(0, 32'h0, 6'd0, 1, 0);
    chk("R6 rsync set", 32'(rd_data[12]), 32'd1);
    step(1, 32'h0000_4000, 6'd0, 0, 0);
    chk("R6 no sw set", 32'(rd_data[14]), 32'd0);

    // R7: write-one clear
    step(1, 32'h0000_2000, 6'd0, 0, 0);
    chk("R7 rsync cleared", 32'(rd_data[12]), 32'd0);
    chk("R7 clr reads 0", 32'(rd_data[13]), 32'd0);
    step(0, 32'h0, 6'd0, 0, 1);
    step(1, 32'h0, 6'd0, 0, 0);
    chk("R7 zero no clear", 32'(rd_data[14]), 32'd1);
    step(1, 32'h0000_8000, 6'd0, 0, 1);
    chk("R7 event wins", 32'(rd_data[14]), 32'd1);
    step(1, 32'h0000_8000, 6'd0, 0, 0);
    chk("R7 wsync cleared", 32'(rd_data[14]), 32'd0);

    // R8 / R9: every selector code with rs=1 ws=0 frame=1 block=0
    step(1, 32'h0, 6'b000010, 1, 0);
    for (int s = 0; s < 8; s++) begin
      logic e;
      step(1, (32'(s) << 16) | 32'h4, 6'd0, 0, 0);
      e = (s == 1) || (s == 2) || (s == 4);
      if (s >= 6) chk("R9 reserved code low", 32'(pin_out), 32'd0);
      else        chk("R8 pin code", 32'(pin_out), 32'(e));
    end

    // R10: reserved bits
    step(1, 32'hFFFF_FFFF, 6'd0, 0, 0);
    chk("R10 reserved zero", 32'(rd_data[31:19]), 32'd0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic we;
      logic [5:0] ce;
      we = ($urandom_range(3) == 0);
      for (int i = 0; i < 6; i++) ce[i] = ($urandom_range(7) == 0);
      step(we, $urandom(), ce, $urandom_range(7) == 0, $urandom_range(7) == 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule